// File: doc/BRIEF.md
# Level-priority interrupt controller

This block gathers a parameterised set of interrupt lines for a single processor hart and reduces them to one request carrying a source number, a level and a vectored flag. Every source owns four byte registers on a simple byte-wide register bus: a pending flag, an enable flag, an attribute byte and a control byte. The attribute byte chooses between level sensing and edge sensing, picks the edge polarity and marks the source as vectored. Software can also set or clear the pending flag of an edge-sensed source directly.

A global configuration field, `nlbits`, sets how the control byte is read. Its upper `nlbits` bits form the source's level and the implemented bits below them form its priority. The field is clamped to the number of implemented control bits, and that count can be read from a fixed info word. A threshold byte blocks every request whose level does not exceed it.

Each cycle the block compares all enabled, pending sources by level, then by priority, then by source number. It registers the winner onto its outputs. The core returns the number of the source it took on an acknowledge input, and this clears an edge-sensed pending flag.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: Register map, byte addresses. 0x000 is the configuration byte: bits [3:0] hold `nlbits` and bits [7:4] read zero. 0x004 to 0x007 is a read-only little-endian info word: bits [11:8] hold the implemented control-bit count (so 0x005 reads that count) and every other bit reads zero. 0x008 is the threshold byte. Source i sits at 0x100 + 4*i, with pending at +0 (bit 0), enable at +1 (bit 0), attribute at +2 (bits [2:0]) and control at +3.
- R2: After reset the configuration, threshold, pending, enable, attribute and implemented control bits are all zero, and `irq_valid` is low. Unimplemented low control bits always read as ones, so with 4 implemented bits an unwritten control byte reads 0x0F.
- R3: With attribute bit 1 clear, the source is level-sensed. Its pending bit follows the input after a two-flop synchroniser plus one register stage, and a bus write to its pending byte has no effect. A change on the input line shows on the request outputs at the fourth rising clock edge after it.
- R4: With attribute bit 1 set, the source is edge-sensed. Attribute bit 2 clear selects rising edges and set selects falling edges. Only the selected edge of the synchronised line sets pending, and the opposite edge leaves pending unchanged.
- R5: When `ack_valid` is high with `ack_id` equal to an edge-sensed source, that source's pending bit clears, unless a new selected edge arrives in the same cycle.
- R6: For an edge-sensed source, a bus write to its pending byte loads bit 0 of the write data into the pending bit.
- R7: The effective `nlbits` is min(configured value, implemented count). The level is the top `nlbits` bits of the control byte with every lower bit forced to one, so `nlbits` = 0 gives level 0xFF.
- R8: Only sources that are both pending and enabled compete. The winner has the highest level, then the highest priority (the control bits below the level field), then the highest source number.
- R9: `irq_valid` rises only when the winner's level is strictly greater than the threshold byte.
- R10: The outputs are registered. A change in register state appears on them at the first rising edge after the write edge. `irq_shv` copies attribute bit 0 of the winner. When `irq_valid` is low, `irq_id`, `irq_level` and `irq_shv` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_SRC | Raw interrupt lines, one per source |
| bus_we | input | 1 | Byte write strobe |
| bus_addr | input | ADDR_W | Byte address for read and write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| ack_valid | input | 1 | Core has taken an interrupt |
| ack_id | input | ID_W | Source number that was taken |
| irq_valid | output | 1 | Interrupt request to the core |
| irq_id | output | ID_W | Winning source number |
| irq_level | output | 8 | Winning source level |
| irq_shv | output | 1 | Winning source is vectored |

## Verification
A line change reaches the request outputs on the fourth rising edge: two synchroniser flops, the pending register, then the output register. A register write or an acknowledge reaches them on the first edge after the edge that captured it. Bus reads are combinational and are due in the same cycle. The driver waits exactly that many edges before it queues an expected item, and the monitor compares each queued item at the following falling edge. Some checks are also placed one edge early, to confirm the outputs have not yet moved.

// File: rtl/lic_pkg.sv
package lic_pkg;
  localparam int NL_W = 4;

  // mask with the upper nl bits of a byte set (nl already clamped to <= 8)
  function automatic logic [7:0] top_mask(input logic [NL_W-1:0] nl);
    logic [7:0] m;
    m = 8'h00;
    for (int b = 0; b < 8; b++) begin
      if (b >= 8 - int'(nl)) m[b] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [NL_W-1:0] clamp_nl(input logic [NL_W-1:0] nl, input int impl);
    return (int'(nl) > impl) ? NL_W'(impl) : nl;
  endfunction

  function automatic logic [7:0] level_of(input logic [7:0] ctl, input logic [NL_W-1:0] nl);
    return (ctl & top_mask(nl)) | ~top_mask(nl);
  endfunction

  function automatic logic [7:0] prio_of(input logic [7:0] ctl, input logic [NL_W-1:0] nl);
    return ctl & ~top_mask(nl);
  endfunction
endpackage

// File: rtl/lic_slot.sv
module lic_slot #(
  parameter int CTL_BITS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_i,
  input  logic       wr_pend,
  input  logic       wr_en,
  input  logic       wr_attr,
  input  logic       wr_ctl,
  input  logic [7:0] wdata,
  input  logic       ack_hit,
  output logic       pend_o,
  output logic       en_o,
  output logic [2:0] attr_o,
  output logic [7:0] ctl_o,
  output logic       sync_o,
  output logic       edge_o
);
  localparam int PAD = 8 - CTL_BITS;

  logic                s1_q, s2_q, prev_q;
  logic                pend_q, en_q;
  logic [2:0]          attr_q;
  logic [CTL_BITS-1:0] ctl_q;
  logic                edge_mode, neg_sel;

  assign edge_mode = attr_q[1];
  assign neg_sel   = attr_q[2];
  assign edge_o    = edge_mode & (neg_sel ? (prev_q & ~s2_q) : (~prev_q & s2_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= line_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (!edge_mode) begin
      pend_q <= s2_q;
    end else if (edge_o) begin
      pend_q <= 1'b1;
    end else if (wr_pend) begin
      pend_q <= wdata[0];
    end else if (ack_hit) begin
      pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      attr_q <= 3'b000;
      ctl_q  <= '0;
    end else begin
      if (wr_en)   en_q   <= wdata[0];
      if (wr_attr) attr_q <= wdata[2:0];
      if (wr_ctl)  ctl_q  <= wdata[7 -: CTL_BITS];
    end
  end

  generate
    if (PAD == 0) begin : g_full
      assign ctl_o = ctl_q;
    end else begin : g_pad
      assign ctl_o = {ctl_q, {PAD{1'b1}}};
    end
  endgenerate

  assign pend_o = pend_q;
  assign en_o   = en_q;
  assign attr_o = attr_q;
  assign sync_o = s2_q;
endmodule

// File: rtl/lic_arbiter.sv
module lic_arbiter
  import lic_pkg::*;
#(
  parameter int NUM_SRC  = 8,
  parameter int ID_W     = 3,
  parameter int CTL_BITS = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_SRC-1:0]      req_vec,
  input  logic [NUM_SRC-1:0][7:0] ctl_vec,
  input  logic [NUM_SRC-1:0]      shv_vec,
  input  logic [NL_W-1:0]         nl_raw,
  input  logic [7:0]              thr,
  output logic                    win_found,
  output logic [7:0]              win_level,
  output logic                    irq_valid,
  output logic [ID_W-1:0]         irq_id,
  output logic [7:0]              irq_level,
  output logic                    irq_shv
);
  logic [NL_W-1:0] nl_eff;
  logic [15:0]     best_key;
  logic [ID_W-1:0] best_id;
  logic            best_shv;
  logic            fire;

  assign nl_eff = clamp_nl(nl_raw, CTL_BITS);

  always_comb begin
    logic [15:0] key_i;
    key_i     = '0;
    win_found = 1'b0;
    best_key  = '0;
    best_id   = '0;
    best_shv  = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      key_i = {level_of(ctl_vec[i], nl_eff), prio_of(ctl_vec[i], nl_eff)};
      if (req_vec[i] && (!win_found || key_i >= best_key)) begin
        win_found = 1'b1;
        best_key  = key_i;
        best_id   = ID_W'(i);
        best_shv  = shv_vec[i];
      end
    end
  end

  assign win_level = best_key[15:8];
  assign fire      = win_found && (win_level > thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_valid <= 1'b0;
      irq_id    <= '0;
      irq_level <= 8'h00;
      irq_shv   <= 1'b0;
    end else begin
      irq_valid <= fire;
      irq_id    <= fire ? best_id   : '0;
      irq_level <= fire ? win_level : 8'h00;
      irq_shv   <= fire ? best_shv  : 1'b0;
    end
  end
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
  import lic_pkg::*;
#(
  parameter int NUM_SRC  = 8,
  parameter int CTL_BITS = 4,
  parameter int ADDR_W   = 12
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_SRC-1:0]              src_i,
  input  logic                            bus_we,
  input  logic [ADDR_W-1:0]               bus_addr,
  input  logic [7:0]                      bus_wdata,
  output logic [7:0]                      bus_rdata,
  input  logic                            ack_valid,
  input  logic [$clog2(NUM_SRC)-1:0]      ack_id,
  output logic                            irq_valid,
  output logic [$clog2(NUM_SRC)-1:0]      irq_id,
  output logic [7:0]                      irq_level,
  output logic                            irq_shv
);
  localparam int ID_W   = $clog2(NUM_SRC);
  localparam int WORD_W = ADDR_W - 2;
  localparam int SLOT0  = 'h100 / 4;

  logic [NL_W-1:0]         cfg_nl_q;
  logic [7:0]              thr_q;
  logic [WORD_W-1:0]       word;
  logic [1:0]              fld;
  logic [NUM_SRC-1:0]      pend_vec, en_vec, req_vec, shv_vec;
  logic [NUM_SRC-1:0]      sync_vec, edge_vec, lvl_vec;
  logic [NUM_SRC-1:0][2:0] attr_vec;
  logic [NUM_SRC-1:0][7:0] ctl_vec;
  logic                    win_found;
  logic [7:0]              win_level;

  assign word = bus_addr[ADDR_W-1:2];
  assign fld  = bus_addr[1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_nl_q <= '0;
      thr_q    <= 8'h00;
    end else if (bus_we) begin
      if (bus_addr == ADDR_W'(0)) cfg_nl_q <= bus_wdata[NL_W-1:0];
      if (bus_addr == ADDR_W'(8)) thr_q    <= bus_wdata;
    end
  end

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_slot
      logic hit;
      assign hit = (word == WORD_W'(SLOT0 + i));
      lic_slot #(.CTL_BITS(CTL_BITS)) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_i  (src_i[i]),
        .wr_pend (bus_we && hit && fld == 2'd0),
        .wr_en   (bus_we && hit && fld == 2'd1),
        .wr_attr (bus_we && hit && fld == 2'd2),
        .wr_ctl  (bus_we && hit && fld == 2'd3),
        .wdata   (bus_wdata),
        .ack_hit (ack_valid && ack_id == ID_W'(i)),
        .pend_o  (pend_vec[i]),
        .en_o    (en_vec[i]),
        .attr_o  (attr_vec[i]),
        .ctl_o   (ctl_vec[i]),
        .sync_o  (sync_vec[i]),
        .edge_o  (edge_vec[i])
      );
      assign shv_vec[i] = attr_vec[i][0];
      assign lvl_vec[i] = ~attr_vec[i][1];
    end
  endgenerate

  assign req_vec = pend_vec & en_vec;

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_addr == ADDR_W'(0)) bus_rdata = {4'h0, cfg_nl_q};
    if (bus_addr == ADDR_W'(5)) bus_rdata = {4'h0, 4'(CTL_BITS)};
    if (bus_addr == ADDR_W'(8)) bus_rdata = thr_q;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (word == WORD_W'(SLOT0 + i)) begin
        case (fld)
          2'd0:    bus_rdata = {7'b0, pend_vec[i]};
          2'd1:    bus_rdata = {7'b0, en_vec[i]};
          2'd2:    bus_rdata = {5'b0, attr_vec[i]};
          default: bus_rdata = ctl_vec[i];
        endcase
      end
    end
  end

  lic_arbiter #(.NUM_SRC(NUM_SRC), .ID_W(ID_W), .CTL_BITS(CTL_BITS)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_vec   (req_vec),
    .ctl_vec   (ctl_vec),
    .shv_vec   (shv_vec),
    .nl_raw    (cfg_nl_q),
    .thr       (thr_q),
    .win_found (win_found),
    .win_level (win_level),
    .irq_valid (irq_valid),
    .irq_id    (irq_id),
    .irq_level (irq_level),
    .irq_shv   (irq_shv)
  );
endmodule

// File: rtl/lic_checker.sv
module lic_checker #(
  parameter int NUM_SRC = 8,
  parameter int ID_W    = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] pend_vec,
  input logic [NUM_SRC-1:0] en_vec,
  input logic [NUM_SRC-1:0] shv_vec,
  input logic [NUM_SRC-1:0] sync_vec,
  input logic [NUM_SRC-1:0] lvl_vec,
  input logic [NUM_SRC-1:0] edge_vec,
  input logic [7:0]         thr_q,
  input logic               irq_valid,
  input logic [ID_W-1:0]    irq_id,
  input logic [7:0]         irq_level,
  input logic               irq_shv
);
  logic [NUM_SRC-1:0] req_prev, shv_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_prev <= '0;
      shv_prev <= '0;
    end else begin
      req_prev <= pend_vec & en_vec;
      shv_prev <= shv_vec;
    end
  end

  a_r3_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_vec ^ $past(sync_vec)) & $past(lvl_vec)) == '0);

  a_r4_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_vec) |=> ((pend_vec & $past(edge_vec)) == $past(edge_vec)));

  a_r8_winner_requested: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> req_prev[irq_id]);

  a_r8_idle_without_request: assert property (@(posedge clk) disable iff (!rst_n)
    (req_prev == '0) |-> !irq_valid);

  a_r9_above_thresh: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_level > $past(thr_q)));

  a_r10_shv_matches: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_shv == shv_prev[irq_id]));

  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_valid |-> (irq_id == '0 && irq_level == 8'h00 && !irq_shv));
endmodule

bind lvl_irq_ctrl lic_checker #(.NUM_SRC(NUM_SRC), .ID_W($clog2(NUM_SRC))) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pend_vec  (pend_vec),
  .en_vec    (en_vec),
  .shv_vec   (shv_vec),
  .sync_vec  (sync_vec),
  .lvl_vec   (lvl_vec),
  .edge_vec  (edge_vec),
  .thr_q     (thr_q),
  .irq_valid (irq_valid),
  .irq_id    (irq_id),
  .irq_level (irq_level),
  .irq_shv   (irq_shv)
);

// File: tb/lvl_irq_ctrl_bench.sv
module lvl_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 8;
  localparam int CBITS = 4;
  localparam int AW = 12;
  localparam int IDW = $clog2(NSRC);

  typedef struct {
    bit         is_rd;
    logic [7:0] rd_exp;
    logic       v;
    logic [IDW-1:0] id;
    logic [7:0] lvl;
    logic       shv;
    string      tag;
  } item_t;

  item_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic clk = 0, rst_n = 0;
  logic [NSRC-1:0] src_i = '0;
  logic bus_we = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0] bus_wdata = 8'h00, bus_rdata;
  logic ack_valid = 0;
  logic [IDW-1:0] ack_id = '0;
  logic irq_valid, irq_shv;
  logic [IDW-1:0] irq_id;
  logic [7:0] irq_level;

  always #(CLK_PERIOD/2) clk = ~clk;

  lvl_irq_ctrl #(.NUM_SRC(NSRC), .CTL_BITS(CBITS), .ADDR_W(AW)) u_lvl_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ack_valid(ack_valid), .ack_id(ack_id),
    .irq_valid(irq_valid), .irq_id(irq_id), .irq_level(irq_level), .irq_shv(irq_shv));

  // independent model of the level rule: keep top n bits, fill the rest with ones
  function automatic logic [7:0] lvl_model(input logic [7:0] ctl, input int nl);
    int n;
    logic [7:0] full;
    n = (nl > CBITS) ? CBITS : nl;
    full = ctl | (8'hFF >> CBITS);
    if (n == 0) return 8'hFF;
    return ((full >> (8 - n)) << (8 - n)) | (8'hFF >> n);
  endfunction

  function automatic logic [AW-1:0] slot(input int i, input int f);
    return AW'(256 + 4 * i + f);
  endfunction

  // monitor: compares every queued expectation at the falling edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_cmp++;
      if (it.is_rd) begin
        if (bus_rdata !== it.rd_exp) begin
          n_bad++;
          $display("FAIL %s: rdata=%h expected=%h", it.tag, bus_rdata, it.rd_exp);
        end
      end else if (irq_valid !== it.v || irq_id !== it.id || irq_level !== it.lvl || irq_shv !== it.shv) begin
        n_bad++;
        $display("FAIL %s: got v=%0b id=%0d lvl=%h shv=%0b expected v=%0b id=%0d lvl=%h shv=%0b",
                 it.tag, irq_valid, irq_id, irq_level, irq_shv, it.v, it.id, it.lvl, it.shv);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    step(1);
    bus_we = 0;
  endtask

  task automatic chk_rd(input logic [AW-1:0] a, input logic [7:0] e, input string tag);
    item_t it;
    bus_addr = a;
    it = '{is_rd: 1, rd_exp: e, v: 0, id: '0, lvl: 8'h00, shv: 0, tag: tag};
    q.push_back(it);
    step(1);
  endtask

  task automatic chk_irq(input logic v, input int id, input logic [7:0] l, input logic s, input string tag);
    item_t it;
    it = '{is_rd: 0, rd_exp: 8'h00, v: v, id: IDW'(id), lvl: l, shv: s, tag: tag};
    q.push_back(it);
    step(1);
  endtask

  task automatic ack(input int id);
    ack_valid = 1; ack_id = IDW'(id);
    step(1);
    ack_valid = 0;
    step(1);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    // R2 reset state, R1 map
    chk_irq(0, 0, 8'h00, 0, "R2 irq idle after reset");
    chk_rd(AW'(0), 8'h00, "R2 cfg reset");
    chk_rd(AW'(8), 8'h00, "R2 threshold reset");
    chk_rd(slot(1, 1), 8'h00, "R2 enable reset");
    chk_rd(slot(0, 3), 8'h0F, "R2 control unimplemented bits read one");
    chk_rd(AW'(5), 8'(CBITS), "R1 info word control-bit count");
    chk_rd(AW'(4), 8'h00, "R1 info word low byte");

    // R3 level sensing, latency
    wr(AW'(0), 8'h02);
    wr(slot(3, 1), 8'h01);
    wr(slot(3, 3), 8'h80);
    chk_rd(slot(3, 3), 8'h8F, "R1 control readback");
    src_i[3] = 1'b1;
    step(3);
    chk_irq(0, 0, 8'h00, 0, "R3 not yet after three edges");
    chk_irq(1, 3, lvl_model(8'h80, 2), 0, "R3 request at fourth edge");
    src_i[3] = 1'b0;
    step(4);
    chk_irq(0, 0, 8'h00, 0, "R3 level drop removes request");

    // R8 ordering
    src_i[3] = 1'b1;
    wr(slot(5, 1), 8'h01);
    wr(slot(5, 3), 8'h80);
    src_i[5] = 1'b1;
    step(4);
    chk_irq(1, 5, lvl_model(8'h80, 2), 0, "R8 tie goes to higher source number");
    wr(slot(3, 3), 8'hA0);
    step(1);
    chk_irq(1, 3, lvl_model(8'hA0, 2), 0, "R8 equal level, higher priority wins");
    wr(slot(5, 3), 8'hC0);
    step(1);
    chk_irq(1, 5, lvl_model(8'hC0, 2), 0, "R8 higher level wins");

    // R9 threshold
    wr(AW'(8), 8'hFF);
    step(1);
    chk_irq(0, 0, 8'h00, 0, "R9 level equal to threshold blocked");
    wr(AW'(8), 8'hFE);
    step(1);
    chk_irq(1, 5, 8'hFF, 0, "R9 level above threshold passes");
    wr(AW'(8), 8'h00);

    // R7 clamp and nlbits = 0
    wr(AW'(0), 8'hFF);
    chk_rd(AW'(0), 8'h0F, "R1 cfg upper bits read zero");
    chk_irq(1, 5, lvl_model(8'hC0, 15), 0, "R7 nlbits clamped to implemented width");
    wr(AW'(0), 8'h00);
    step(1);
    chk_irq(1, 5, lvl_model(8'hC0, 0), 0, "R7 nlbits zero gives level FF");
    wr(AW'(0), 8'h04);
    step(1);
    chk_irq(1, 5, 8'hCF, 0, "R7 full-width level");

    // R4 rising edge, R10 vectored flag, R5 ack
    wr(slot(1, 2), 8'h03);
    wr(slot(1, 1), 8'h01);
    wr(slot(1, 3), 8'hF0);
    src_i[1] = 1'b1;
    step(4);
    chk_irq(1, 1, 8'hFF, 1, "R10 vectored flag of winner");
    chk_rd(slot(1, 0), 8'h01, "R4 rising edge sets pending");
    ack(1);
    chk_irq(1, 5, 8'hCF, 0, "R5 ack clears edge pending");
    chk_rd(slot(1, 0), 8'h00, "R5 held line does not re-arm");

    // R4 falling edge
    wr(slot(1, 1), 8'h00);
    wr(slot(2, 2), 8'h06);
    wr(slot(2, 1), 8'h01);
    wr(slot(2, 3), 8'hE0);
    src_i[2] = 1'b1;
    step(5);
    chk_irq(1, 5, 8'hCF, 0, "R4 rising edge ignored in falling mode");
    chk_rd(slot(2, 0), 8'h00, "R4 pending stays clear on wrong edge");
    src_i[2] = 1'b0;
    step(4);
    chk_irq(1, 2, 8'hEF, 0, "R4 falling edge sets pending");
    ack(2);
    chk_irq(1, 5, 8'hCF, 0, "R5 ack clears falling-edge source");

    // R6 software pending
    wr(slot(6, 2), 8'h02);
    wr(slot(6, 1), 8'h01);
    wr(slot(6, 3), 8'hD0);
    wr(slot(6, 0), 8'h01);
    chk_rd(slot(6, 0), 8'h01, "R6 software set pending");
    chk_irq(1, 6, 8'hDF, 0, "R6 software pending raises request");
    wr(slot(6, 0), 8'h00);
    step(1);
    chk_irq(1, 5, 8'hCF, 0, "R6 software clear drops request");

    // R8 disabled source does not compete
    wr(slot(0, 2), 8'h02);
    wr(slot(0, 3), 8'hF0);
    wr(slot(0, 0), 8'h01);
    step(1);
    chk_irq(1, 5, 8'hCF, 0, "R8 disabled pending source ignored");
    chk_rd(slot(0, 0), 8'h01, "R8 disabled source keeps pending");
    wr(slot(0, 1), 8'h01);
    step(1);
    chk_irq(1, 0, 8'hFF, 0, "R8 enabled source now wins");
    wr(slot(0, 0), 8'h00);

    // R3 software write ignored in level mode
    wr(slot(3, 0), 8'h00);
    chk_rd(slot(3, 0), 8'h01, "R3 pending write ignored for level source");

    // R10 idle outputs
    wr(slot(3, 1), 8'h00);
    wr(slot(5, 1), 8'h00);
    step(1);
    chk_irq(0, 0, 8'h00, 0, "R10 no request leaves outputs zero");

    step(2);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule